// File: doc/BRIEF.md
# Palette Controller Host Register Port

This block is the host side of a display palette controller. An external processor reaches it over a byte-wide asynchronous bus with active-low read and write strobes and a two-bit register select. The block brings both strobes into the system clock domain and finds their edges. It then decodes four registers: a write pointer into the colour table, a colour data port, a pixel mask and a read pointer into the colour table. Read data is returned on an output byte with an enable that a pad ring turns into a tri-state driver.

Colour entries pass through the data port as three bytes in the order red, green, blue. The pointer moves on only after the third byte of a triple. A mode input picks how colour bytes are handled. In narrow mode only the low six bits are kept, and the top two bits read back as zero. In wide mode all eight bits are kept. The colour table sits behind the data port and is sized by a parameter.

The bus timing assumes each strobe is held low for at least four system clocks and stays high for at least four clocks between accesses. Register select and write data must be valid from the falling edge to the rising edge that the block acts on.

Top module: `pal_host_port`

## Requirements
- R1: A synchronous reset clears the two pointers, the pixel mask, every colour table entry and the triple position to zero, and drops the output enable.
- R2: The register select value (0 = write pointer, 1 = colour data, 2 = pixel mask, 3 = read pointer) is taken when the falling edge of a strobe is detected. A change of select while the strobe stays low does not move the access to another register.
- R3: Write data is taken on the rising edge of the write strobe. Earlier values on the data input during the same strobe have no effect.
- R4: `host_doe` is high only during a read, rising after the read strobe falls and dropping after it rises. While `host_doe` is low, `host_dout` is 0x00.
- R5: A read returns the selected register. Pointers are zero-extended to eight bits.
- R6: With `colour_wide` = 0, bits 7 and 6 of each colour byte written through the data port are discarded, and colour bytes read through the data port have bits 7 and 6 at 0.
- R7: With `colour_wide` = 1, all eight bits of each colour byte are stored and returned.
- R8: Colour writes fill red, green, blue in turn. The table entry at the write pointer is written and the pointer goes up by one only after the blue byte. Writing the write pointer restarts the triple at red, and an unfinished triple is dropped.
- R9: Colour reads return red, green, blue of the entry at the read pointer in turn. The pointer goes up by one after the blue byte is read. Writing the read pointer restarts the read triple at red.
- R10: The pixel mask stores and returns all eight bits in either colour mode.
- R11: Both pointers wrap from the last table entry to entry 0 when they advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| host_rd_n | input | 1 | Asynchronous read strobe, active low |
| host_wr_n | input | 1 | Asynchronous write strobe, active low |
| host_sel | input | 2 | Register select |
| host_din | input | 8 | Write data from the host bus |
| host_dout | output | 8 | Read data toward the host bus pad |
| host_doe | output | 1 | Output enable for the host bus pad |
| colour_wide | input | 1 | 1 = eight-bit colour bytes, 0 = six-bit colour bytes |

## Verification
The bench builds the block with the default four-bit pointers and a two-stage synchroniser. With a sixteen-entry colour table, wrap-around of both pointers is reached within one triple from the last entry. The table also holds the colour entries that the narrow and wide mode checks use. Each access holds its strobe low long enough for the synchroniser delay to pass, so the bench can change select and data partway through a strobe and show which value was taken.

// File: rtl/pal_port_pkg.sv
package pal_port_pkg;

    localparam int BUS_W    = 8;
    localparam int NARROW_W = 6;

    typedef enum logic [1:0] {
        SEL_WPTR  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_RPTR  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [BUS_W-1:0] red;
        logic [BUS_W-1:0] green;
        logic [BUS_W-1:0] blue;
    } rgb_t;

    // Keep only the low bits of a colour byte when narrow mode is active.
    function automatic logic [BUS_W-1:0] fit_colour(input logic [BUS_W-1:0] v,
                                                    input logic wide);
        logic [BUS_W-1:0] keep;
        keep = {BUS_W{1'b1}} >> (BUS_W - NARROW_W);
        return wide ? v : (v & keep);
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/pal_strobe_sync.sv
module pal_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= strobe_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], strobe_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign fall = prev_q & ~chain_q[LAST];
    assign rise = ~prev_q & chain_q[LAST];

endmodule

// File: rtl/pal_colour_table.sv
module pal_colour_table
    import pal_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  rgb_t              wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  phase_e            rphase,
    output logic [BUS_W-1:0]  rbyte
);
    localparam int DEPTH = 1 << ADDR_W;

    rgb_t mem_q [DEPTH];
    rgb_t entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign entry = mem_q[raddr];

    always_comb begin
        case (rphase)
            PH_RED:   rbyte = entry.red;
            PH_GREEN: rbyte = entry.green;
            default:  rbyte = entry.blue;
        endcase
    end

endmodule

// File: rtl/pal_read_mux.sv
module pal_read_mux
    import pal_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  reg_sel_e          sel,
    input  logic [ADDR_W-1:0] wptr,
    input  logic [ADDR_W-1:0] rptr,
    input  logic [BUS_W-1:0]  mask,
    input  logic [BUS_W-1:0]  colour_byte,
    input  logic              wide,
    output logic [BUS_W-1:0]  value
);
    always_comb begin
        value = '0;
        case (sel)
            SEL_WPTR: value[ADDR_W-1:0] = wptr;
            SEL_DATA: value = fit_colour(colour_byte, wide);
            SEL_MASK: value = mask;
            default:  value[ADDR_W-1:0] = rptr;
        endcase
    end

endmodule

// File: rtl/pal_host_port.sv
module pal_host_port
    import pal_port_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       host_doe,
    input  logic       colour_wide
);
    logic rd_fall, rd_rise, wr_fall, wr_rise;

    reg_sel_e          sel_q;
    logic [ADDR_W-1:0] wptr_q, rptr_q;
    logic [BUS_W-1:0]  mask_q;
    phase_e            wr_phase_q, rd_phase_q;
    logic [BUS_W-1:0]  stage_red_q, stage_green_q;
    logic              rd_load_q;
    logic [BUS_W-1:0]  dout_q;
    logic              doe_q;

    logic              tbl_we;
    rgb_t              tbl_wdata;
    logic [BUS_W-1:0]  tbl_rbyte;
    logic [BUS_W-1:0]  wr_colour;
    logic [BUS_W-1:0]  rd_value;

    pal_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_n(host_rd_n), .fall(rd_fall), .rise(rd_rise)
    );

    pal_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_n(host_wr_n), .fall(wr_fall), .rise(wr_rise)
    );

    assign wr_colour = fit_colour(host_din, colour_wide);
    assign tbl_we    = wr_rise && (sel_q == SEL_DATA) && (wr_phase_q == PH_BLUE);
    assign tbl_wdata = '{red: stage_red_q, green: stage_green_q, blue: wr_colour};

    pal_colour_table #(.ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst(rst),
        .we(tbl_we), .waddr(wptr_q), .wdata(tbl_wdata),
        .raddr(rptr_q), .rphase(rd_phase_q), .rbyte(tbl_rbyte)
    );

    pal_read_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel(sel_q), .wptr(wptr_q), .rptr(rptr_q), .mask(mask_q),
        .colour_byte(tbl_rbyte), .wide(colour_wide), .value(rd_value)
    );

    // Select capture on either strobe's falling edge
    always_ff @(posedge clk) begin
        if (rst)                    sel_q <= SEL_WPTR;
        else if (rd_fall || wr_fall) sel_q <= reg_sel_e'(host_sel);
    end

    // Write side
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q        <= '0;
            mask_q        <= '0;
            wr_phase_q    <= PH_RED;
            stage_red_q   <= '0;
            stage_green_q <= '0;
        end else if (wr_rise) begin
            case (sel_q)
                SEL_WPTR: begin
                    wptr_q     <= host_din[ADDR_W-1:0];
                    wr_phase_q <= PH_RED;
                end
                SEL_DATA: begin
                    case (wr_phase_q)
                        PH_RED:   stage_red_q   <= wr_colour;
                        PH_GREEN: stage_green_q <= wr_colour;
                        default:  wptr_q        <= wptr_q + 1'b1;
                    endcase
                    wr_phase_q <= next_phase(wr_phase_q);
                end
                SEL_MASK: mask_q <= host_din;
                default: ;
            endcase
        end
    end

    // Read pointer and read triple position
    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q     <= '0;
            rd_phase_q <= PH_RED;
        end else if (wr_rise && sel_q == SEL_RPTR) begin
            rptr_q     <= host_din[ADDR_W-1:0];
            rd_phase_q <= PH_RED;
        end else if (rd_rise && sel_q == SEL_DATA) begin
            if (rd_phase_q == PH_BLUE) rptr_q <= rptr_q + 1'b1;
            rd_phase_q <= next_phase(rd_phase_q);
        end
    end

    // Read data return and output enable
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_load_q <= 1'b0;
            dout_q    <= '0;
            doe_q     <= 1'b0;
        end else begin
            rd_load_q <= rd_fall;
            if (rd_rise) begin
                dout_q <= '0;
                doe_q  <= 1'b0;
            end else if (rd_load_q) begin
                dout_q <= rd_value;
                doe_q  <= 1'b1;
            end
        end
    end

    assign host_dout = dout_q;
    assign host_doe  = doe_q;

endmodule

// File: rtl/pal_host_port_chk.sv
module pal_host_port_chk
    import pal_port_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rd_n,
    input logic [7:0]        host_dout,
    input logic              host_doe,
    input logic              colour_wide,
    input logic              tbl_we,
    input rgb_t              tbl_wdata,
    input logic [ADDR_W-1:0] wptr_q,
    input logic [ADDR_W-1:0] rptr_q,
    input logic              rd_rise,
    input reg_sel_e          sel_q,
    input phase_e            rd_phase_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wptr_q == '0 && rptr_q == '0 && !host_doe));

    // R4
    doe_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_doe) |-> !$past(host_rd_n));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !host_doe |-> host_dout == 8'h00);

    // R6
    narrow_store_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && !colour_wide) |-> tbl_wdata.blue[7:6] == 2'b00);

    // R8
    wptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        tbl_we |=> wptr_q == ADDR_W'($past(wptr_q) + 1'b1));

    // R9
    rptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && sel_q == SEL_DATA && rd_phase_q == PH_BLUE)
            |=> rptr_q == ADDR_W'($past(rptr_q) + 1'b1));

endmodule

bind pal_host_port pal_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .host_rd_n(host_rd_n),
    .host_dout(host_dout), .host_doe(host_doe), .colour_wide(colour_wide),
    .tbl_we(tbl_we), .tbl_wdata(tbl_wdata),
    .wptr_q(wptr_q), .rptr_q(rptr_q),
    .rd_rise(rd_rise), .sel_q(sel_q), .rd_phase_q(rd_phase_q)
);

// File: tb/pal_host_port_bench.sv
module pal_host_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic       host_doe;
    logic       colour_wide = 1'b0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pal_host_port u_pal_host_port (
        .clk(clk), .rst(rst), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_sel(host_sel), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .colour_wide(colour_wide)
    );

    typedef struct packed {
        logic       is_wr;
        logic [1:0] sel;
        logic       wide;
        logic [7:0] data;
        logic [7:0] want;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd0, 1'b0, 8'h03, 8'h00},
        '{1'b1, 2'd1, 1'b0, 8'hFF, 8'h00},
        '{1'b1, 2'd1, 1'b0, 8'h81, 8'h00},
        '{1'b1, 2'd1, 1'b0, 8'h2A, 8'h00},
        '{1'b0, 2'd0, 1'b0, 8'h00, 8'h04},
        '{1'b1, 2'd1, 1'b1, 8'hC5, 8'h00},
        '{1'b1, 2'd1, 1'b1, 8'h7E, 8'h00},
        '{1'b1, 2'd1, 1'b1, 8'h80, 8'h00},
        '{1'b1, 2'd3, 1'b0, 8'h03, 8'h00},
        '{1'b0, 2'd1, 1'b0, 8'h00, 8'h3F},
        '{1'b0, 2'd1, 1'b0, 8'h00, 8'h01},
        '{1'b0, 2'd1, 1'b0, 8'h00, 8'h2A},
        '{1'b0, 2'd3, 1'b0, 8'h00, 8'h04},
        '{1'b0, 2'd1, 1'b1, 8'h00, 8'hC5},
        '{1'b0, 2'd1, 1'b1, 8'h00, 8'h7E},
        '{1'b0, 2'd1, 1'b1, 8'h00, 8'h80},
        '{1'b1, 2'd2, 1'b0, 8'hC3, 8'h00},
        '{1'b0, 2'd2, 1'b0, 8'h00, 8'hC3},
        '{1'b0, 2'd3, 1'b0, 8'h00, 8'h05}
    };

    function automatic string vec_tag(input int i);
        case (i)
            4:         return "R8";
            9, 10, 11: return "R6";
            12:        return "R9";
            13, 14, 15: return "R7";
            17:        return "R10";
            default:   return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One bus access with the strobe held low for seven clocks.
    task automatic bus_op(input logic wr, input logic [1:0] sel, input logic [7:0] d,
                          input logic wide, output logic [7:0] got, output logic oe);
        @(negedge clk);
        host_sel = sel; host_din = d; colour_wide = wide;
        if (wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        repeat (7) @(negedge clk);
        got = host_dout; oe = host_doe;
        host_wr_n = 1'b1; host_rd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_op(input logic [1:0] sel, input logic [7:0] d, input logic wide);
        logic [7:0] g; logic o;
        bus_op(1'b1, sel, d, wide, g, o);
    endtask

    task automatic rd_check(input string req, input logic [1:0] sel, input logic wide,
                            input logic [7:0] exp);
        logic [7:0] g; logic o;
        bus_op(1'b0, sel, 8'h00, wide, g, o);
        check(req, g, exp);
        check("R4", {7'd0, o}, 8'h01);
        check("R4", {7'd0, host_doe}, 8'h00);
    endtask

    // Write whose select and data change while the strobe is low.
    task automatic wr_switch(input logic [1:0] sel0, input logic [1:0] sel1,
                             input logic [7:0] d0, input logic [7:0] d1);
        @(negedge clk);
        host_sel = sel0; host_din = d0; colour_wide = 1'b1;
        host_wr_n = 1'b0;
        repeat (5) @(negedge clk);
        host_sel = sel1; host_din = d1;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        check("R1", {7'd0, host_doe}, 8'h00);
        check("R4", host_dout, 8'h00);
        rd_check("R1", 2'd0, 1'b1, 8'h00);
        rd_check("R1", 2'd2, 1'b1, 8'h00);
        rd_check("R1", 2'd3, 1'b1, 8'h00);
        rd_check("R1", 2'd1, 1'b1, 8'h00);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) wr_op(VECS[i].sel, VECS[i].data, VECS[i].wide);
            else rd_check(vec_tag(i), VECS[i].sel, VECS[i].wide, VECS[i].want);
        end

        // R11 pointer wrap
        wr_op(2'd0, 8'h0F, 1'b1);
        wr_op(2'd1, 8'h01, 1'b1);
        wr_op(2'd1, 8'h02, 1'b1);
        wr_op(2'd1, 8'h03, 1'b1);
        rd_check("R11", 2'd0, 1'b1, 8'h00);
        wr_op(2'd3, 8'h0F, 1'b1);
        rd_check("R9", 2'd1, 1'b1, 8'h01);
        rd_check("R9", 2'd1, 1'b1, 8'h02);
        rd_check("R9", 2'd1, 1'b1, 8'h03);
        rd_check("R11", 2'd3, 1'b1, 8'h00);

        // R8 pointer write restarts the triple
        wr_op(2'd0, 8'h05, 1'b1);
        wr_op(2'd1, 8'hEE, 1'b1);
        wr_op(2'd0, 8'h06, 1'b1);
        wr_op(2'd1, 8'h11, 1'b1);
        wr_op(2'd1, 8'h22, 1'b1);
        wr_op(2'd1, 8'h33, 1'b1);
        wr_op(2'd3, 8'h06, 1'b1);
        rd_check("R8", 2'd1, 1'b1, 8'h11);
        rd_check("R8", 2'd1, 1'b1, 8'h22);
        rd_check("R8", 2'd1, 1'b1, 8'h33);
        wr_op(2'd3, 8'h05, 1'b1);
        rd_check("R8", 2'd1, 1'b1, 8'h00);

        // R2 select taken at the falling edge
        wr_op(2'd0, 8'h02, 1'b1);
        wr_switch(2'd2, 2'd0, 8'h5A, 8'h5A);
        rd_check("R2", 2'd2, 1'b1, 8'h5A);
        rd_check("R2", 2'd0, 1'b1, 8'h02);

        // R3 data taken at the rising edge
        wr_switch(2'd2, 2'd2, 8'h11, 8'h9C);
        rd_check("R3", 2'd2, 1'b1, 8'h9C);

        // R1 reset during operation
        wr_op(2'd2, 8'h77, 1'b1);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        rd_check("R1", 2'd2, 1'b1, 8'h00);
        rd_check("R1", 2'd0, 1'b1, 8'h00);
        wr_op(2'd3, 8'h03, 1'b1);
        rd_check("R1", 2'd1, 1'b1, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule